// File: doc/BRIEF.md
# Three-Channel Reload Down-Timer

The block holds three independent 32-bit down-counting channels behind a 16-bit peripheral bus. Each channel has a counter and a constant register. It steps down once for every count-enable pulse from its chosen source. When it is at zero and gets one more pulse, it loads the constant again instead of wrapping to all ones. That step also raises the channel's underflow flag, and the flag drives an interrupt request when the channel's interrupt enable is set.

Every count-enable pulse comes from one shared prescaler, so the whole block runs on the peripheral clock alone. The pulse rates are the peripheral clock divided by 4, 16, 64 and 256. A fifth source is a slow external tick, which is brought into the clock domain before use. Software picks the rate so that the channel count rate stays at or below 2 MHz.

The bus is half as wide as a counter, so the counter is read in two accesses. The first half-read of a pair freezes the whole counter in a snapshot. The second half-read returns its half from that snapshot, so a borrow between the halves cannot split the value.

Top module: `tick_timer_unit`

## Requirements
- R1: After reset every register reads 0, every start bit is clear and all `irq` bits are 0.
- R2: Word map: address 0 is the start register, with bit c starting channel c. Channel c uses base 1+5c, with these offsets: +0 constant high half, +1 constant low half, +2 counter high half, +3 counter low half, +4 control word. Read data appears on `bus_rdata` in the cycle after the read access.
- R3: Constant and counter halves can be written and read back at any time. A counter write takes priority over a count step in the same cycle.
- R4: While its start bit is set, a channel's counter drops by exactly one for each pulse of its selected source. While the start bit is clear, pulses are ignored and the counter holds.
- R5: A pulse that arrives with the counter at 0 loads the constant register, not 0xFFFFFFFF, and sets the underflow flag.
- R6: Control word fields: bits [2:0] clock select, bit 5 interrupt enable, bit 8 underflow flag. Writing 0 to bit 8 clears the flag. Writing 1 to bit 8 leaves it as it is. An underflow in the same cycle as a clearing write wins.
- R7: `irq[c]` is the registered AND of channel c's flag and interrupt enable.
- R8: Clock select codes: 0 counts every 4 clocks, 1 every 16, 2 every 64, 3 every 256, and 4 counts rising edges of `ext_tick` after a two-flop synchronizer. Codes 5 to 7 never count.
- R9: Coherent read: the first read of either counter half captures all 32 bits and returns that half from the live count. A following read of the other half returns the captured half. A read of the same half again starts a new capture.
- R10: The channels are independent: writes, counts and flags of one channel do not affect another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_tick | input | 1 | Slow external tick, asynchronous |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | CNT_W/2 | Write data |
| bus_rdata | output | CNT_W/2 | Registered read data |
| irq | output | NUM_CH | Per-channel interrupt requests |

## Verification
The bench builds the block with its default values: three channels, 32-bit counters, a 5-bit word address and an 8-bit prescaler. The bench loads counters directly with small values and with values near a half boundary. This makes the zero-to-reload step and the borrow across the two halves reachable in a few thousand cycles, even with full-width counters. Because the slowest tap fires every 256 clocks, the rate of every prescaler tap can be measured inside short windows. The external-tick source gives exact per-pulse control, which the random phase uses to compare all three counters against a reference model.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int N_DIV    = 4;          // number of prescaler taps
  localparam int NUM_SRC  = N_DIV + 1;  // taps plus external tick
  localparam int SEL_W    = 3;
  localparam int CTL_IEN  = 5;
  localparam int CTL_FLAG = 8;
  localparam int REG_PER_CH = 5;
  localparam int OFS_CST_HI = 0;
  localparam int OFS_CST_LO = 1;
  localparam int OFS_CNT_HI = 2;
  localparam int OFS_CNT_LO = 3;
  localparam int OFS_CTL    = 4;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
#(
  parameter int NDIV = N_DIV,
  localparam int PRE_W = 2 * NDIV
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ext_tick,
  output logic [NDIV:0] taps_o
);
  logic [PRE_W-1:0] pre_q;
  logic [2:0]       sync_q;
  logic [NDIV:0]    taps_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q  <= '0;
      sync_q <= '0;
      taps_o <= '0;
    end else begin
      pre_q  <= pre_q + 1'b1;
      sync_q <= {sync_q[1:0], ext_tick};
      taps_o <= taps_d;
    end
  end

  // Tap k pulses once every 4^(k+1) clocks: all low 2k+2 bits set.
  for (genvar k = 0; k < NDIV; k++) begin : g_tap
    assign taps_d[k] = &pre_q[2*k+1:0];
  end

  // Rising edge of the synchronized tick.
  assign taps_d[NDIV] = sync_q[1] & ~sync_q[2];
endmodule

// File: rtl/tmr_snap.sv
module tmr_snap #(
  parameter int CNT_W = 32,
  localparam int HW = CNT_W / 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt,
  input  logic             rd_hi,
  input  logic             rd_lo,
  output logic [HW-1:0]    half_o
);
  logic [CNT_W-1:0] snap_q;
  logic             pend_q;
  logic             pend_hi_q;   // 1: high half was read first
  logic             use_hi;
  logic             use_lo;

  assign use_hi = rd_hi & pend_q & ~pend_hi_q;
  assign use_lo = rd_lo & pend_q &  pend_hi_q;

  always_comb begin
    half_o = '0;
    if (use_hi)     half_o = snap_q[CNT_W-1:HW];
    else if (use_lo) half_o = snap_q[HW-1:0];
    else if (rd_hi) half_o = cnt[CNT_W-1:HW];
    else if (rd_lo) half_o = cnt[HW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      snap_q    <= '0;
      pend_q    <= 1'b0;
      pend_hi_q <= 1'b0;
    end else if (use_hi || use_lo) begin
      pend_q <= 1'b0;
    end else if (rd_hi || rd_lo) begin
      snap_q    <= cnt;
      pend_q    <= 1'b1;
      pend_hi_q <= rd_hi;
    end
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32,
  localparam int HW = CNT_W / 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             tick,
  input  logic             wr_cst_hi,
  input  logic             wr_cst_lo,
  input  logic             wr_cnt_hi,
  input  logic             wr_cnt_lo,
  input  logic             wr_ctl,
  input  logic [HW-1:0]    wdata,
  output logic [CNT_W-1:0] cst_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [SEL_W-1:0] sel_o,
  output logic             ien_o,
  output logic             flag_o,
  output logic             irq_o
);
  logic step;
  logic uflow;

  assign step  = start & tick & ~(wr_cnt_hi | wr_cnt_lo);
  assign uflow = step & (cnt_o == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cst_o  <= '0;
      cnt_o  <= '0;
      sel_o  <= '0;
      ien_o  <= 1'b0;
      flag_o <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      if (wr_cst_hi) cst_o[CNT_W-1:HW] <= wdata;
      if (wr_cst_lo) cst_o[HW-1:0]     <= wdata;
      if (wr_cnt_hi) cnt_o[CNT_W-1:HW] <= wdata;
      if (wr_cnt_lo) cnt_o[HW-1:0]     <= wdata;
      if (uflow)     cnt_o <= cst_o;
      else if (step) cnt_o <= cnt_o - 1'b1;
      if (wr_ctl) begin
        sel_o <= wdata[SEL_W-1:0];
        ien_o <= wdata[CTL_IEN];
        if (!wdata[CTL_FLAG]) flag_o <= 1'b0;
      end
      if (uflow) flag_o <= 1'b1;
      irq_o <= flag_o & ien_o;
    end
  end
endmodule

// File: rtl/tick_timer_unit.sv
module tick_timer_unit
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 5,
  localparam int BUS_W = CNT_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ext_tick,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic [NUM_CH-1:0] irq
);
  logic [NUM_CH-1:0]             start_q;
  logic [NUM_SRC-1:0]            taps;
  logic [NUM_CH-1:0][CNT_W-1:0]  cnt_a;
  logic [NUM_CH-1:0][CNT_W-1:0]  cst_a;
  logic [NUM_CH-1:0][SEL_W-1:0]  sel_a;
  logic [NUM_CH-1:0]             ien_a;
  logic [NUM_CH-1:0]             flag_a;
  logic [NUM_CH-1:0]             en_a;
  logic [NUM_CH-1:0]             cnt_wr_a;
  logic [NUM_CH-1:0][BUS_W-1:0]  half_a;
  logic [BUS_W-1:0]              rd_word;
  logic                          wr_acc;
  logic                          rd_acc;

  assign wr_acc = bus_sel &  bus_wr;
  assign rd_acc = bus_sel & ~bus_wr;

  tmr_prescaler #(.NDIV(N_DIV)) pre_i (
    .clk(clk), .rst(rst), .ext_tick(ext_tick), .taps_o(taps)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int BASE = 1 + c * REG_PER_CH;
    logic hit_cst_hi, hit_cst_lo, hit_cnt_hi, hit_cnt_lo, hit_ctl;

    assign hit_cst_hi = bus_addr == ADDR_W'(BASE + OFS_CST_HI);
    assign hit_cst_lo = bus_addr == ADDR_W'(BASE + OFS_CST_LO);
    assign hit_cnt_hi = bus_addr == ADDR_W'(BASE + OFS_CNT_HI);
    assign hit_cnt_lo = bus_addr == ADDR_W'(BASE + OFS_CNT_LO);
    assign hit_ctl    = bus_addr == ADDR_W'(BASE + OFS_CTL);
    assign cnt_wr_a[c] = wr_acc & (hit_cnt_hi | hit_cnt_lo);

    always_comb begin
      en_a[c] = 1'b0;
      for (int s = 0; s < NUM_SRC; s++)
        if (sel_a[c] == SEL_W'(s)) en_a[c] = taps[s];
    end

    tmr_channel #(.CNT_W(CNT_W)) ch_i (
      .clk(clk), .rst(rst), .start(start_q[c]), .tick(en_a[c]),
      .wr_cst_hi(wr_acc & hit_cst_hi), .wr_cst_lo(wr_acc & hit_cst_lo),
      .wr_cnt_hi(wr_acc & hit_cnt_hi), .wr_cnt_lo(wr_acc & hit_cnt_lo),
      .wr_ctl(wr_acc & hit_ctl), .wdata(bus_wdata),
      .cst_o(cst_a[c]), .cnt_o(cnt_a[c]), .sel_o(sel_a[c]),
      .ien_o(ien_a[c]), .flag_o(flag_a[c]), .irq_o(irq[c])
    );

    tmr_snap #(.CNT_W(CNT_W)) snap_i (
      .clk(clk), .rst(rst), .cnt(cnt_a[c]),
      .rd_hi(rd_acc & hit_cnt_hi), .rd_lo(rd_acc & hit_cnt_lo),
      .half_o(half_a[c])
    );
  end

  always_comb begin
    rd_word = '0;
    if (bus_addr == '0) rd_word = BUS_W'(start_q);
    for (int c = 0; c < NUM_CH; c++) begin
      if (bus_addr == ADDR_W'(1 + c*REG_PER_CH + OFS_CST_HI)) rd_word = cst_a[c][CNT_W-1:BUS_W];
      if (bus_addr == ADDR_W'(1 + c*REG_PER_CH + OFS_CST_LO)) rd_word = cst_a[c][BUS_W-1:0];
      if (bus_addr == ADDR_W'(1 + c*REG_PER_CH + OFS_CNT_HI)) rd_word = half_a[c];
      if (bus_addr == ADDR_W'(1 + c*REG_PER_CH + OFS_CNT_LO)) rd_word = half_a[c];
      if (bus_addr == ADDR_W'(1 + c*REG_PER_CH + OFS_CTL)) begin
        rd_word = '0;
        rd_word[SEL_W-1:0] = sel_a[c];
        rd_word[CTL_IEN]   = ien_a[c];
        rd_word[CTL_FLAG]  = flag_a[c];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q   <= '0;
      bus_rdata <= '0;
    end else begin
      if (wr_acc && bus_addr == '0) start_q <= bus_wdata[NUM_CH-1:0];
      if (rd_acc) bus_rdata <= rd_word;
    end
  end
endmodule

// File: rtl/tmr_unit_chk.sv
module tmr_unit_chk
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int CNT_W  = 32
) (
  input logic                         clk,
  input logic                         rst,
  input logic [NUM_CH-1:0]            start,
  input logic [NUM_SRC-1:0]           taps,
  input logic [NUM_CH-1:0][CNT_W-1:0] cnt,
  input logic [NUM_CH-1:0][CNT_W-1:0] cst,
  input logic [NUM_CH-1:0]            flag,
  input logic [NUM_CH-1:0]            ien,
  input logic [NUM_CH-1:0]            en,
  input logic [NUM_CH-1:0]            cnt_wr,
  input logic [NUM_CH-1:0]            irq
);
  AST_TAP_NEST_HI: assert property (@(posedge clk) disable iff (rst)
    taps[3] |-> taps[2] && taps[1] && taps[0]); // R8
  AST_TAP_NEST_LO: assert property (@(posedge clk) disable iff (rst)
    taps[1] |-> taps[0]); // R8

  for (genvar c = 0; c < NUM_CH; c++) begin : g_c
    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
      (start[c] && en[c] && !cnt_wr[c] && cnt[c] != '0) |=> cnt[c] == $past(cnt[c]) - 1'b1); // R4
    AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (rst)
      (!start[c] && !cnt_wr[c]) |=> $stable(cnt[c])); // R4
    AST_RELOAD_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
      (start[c] && en[c] && !cnt_wr[c] && cnt[c] == '0) |=> cnt[c] == $past(cst[c])); // R5
    AST_FLAG_ON_WRAP: assert property (@(posedge clk) disable iff (rst)
      (start[c] && en[c] && !cnt_wr[c] && cnt[c] == '0) |=> flag[c]); // R5
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
      irq[c] |-> $past(flag[c]) && $past(ien[c])); // R7
  end
endmodule

bind tick_timer_unit tmr_unit_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst(rst), .start(start_q), .taps(taps), .cnt(cnt_a),
  .cst(cst_a), .flag(flag_a), .ien(ien_a), .en(en_a), .cnt_wr(cnt_wr_a),
  .irq(irq)
);

// File: tb/tick_timer_unit_tb_top.sv
module tick_timer_unit_tb_top;
  localparam int NCH = 3;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ext_tick = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [2:0]  irq;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tick_timer_unit dut_i (
    .clk(clk), .rst(rst), .ext_tick(ext_tick), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  function automatic logic [4:0] ad(int ch, int ofs);
    return 5'(1 + ch*5 + ofs);
  endfunction
  function automatic logic [15:0] ctl(int sel, bit ien, bit flg);
    return 16'(sel) | (16'(ien) << 5) | (16'(flg) << 8);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask
  task automatic chk_rng(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask
  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk); bus_sel = 0; d = bus_rdata;
  endtask
  task automatic wr32(input int ch, input int ofs, input logic [31:0] v);
    wr(ad(ch, ofs), v[31:16]);
    wr(ad(ch, ofs+1), v[15:0]);
  endtask
  task automatic rd_cnt(input int ch, output logic [31:0] v);
    logic [15:0] h, l;
    rd(ad(ch, 2), h);
    rd(ad(ch, 3), l);
    v = {h, l};
  endtask
  task automatic pulse();
    @(negedge clk); ext_tick = 1;
    repeat (4) @(negedge clk);
    ext_tick = 0;
    repeat (4) @(negedge clk);
  endtask
  task automatic rate(input int sel, input int cyc, input int lo, input int hi, input string req);
    logic [31:0] v;
    wr32(0, 2, 32'd100000);
    wr(ad(0, 4), ctl(sel, 0, 0));
    wr(5'd0, 16'h1);
    repeat (cyc - 1) @(negedge clk);
    wr(5'd0, 16'h0);
    rd_cnt(0, v);
    chk_rng(req, 100000 - int'(v), lo, hi);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    logic [31:0] v;
    logic [31:0] m_cnt [NCH];
    logic [31:0] m_cst [NCH];
    bit          m_flg [NCH];
    bit          m_ien [NCH];
    int unsigned seed_v;
    seed_v = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rst = 0;

    // R1 reset state over the whole map
    for (int a = 0; a < 16; a++) begin
      rd(5'(a), d);
      chk($sformatf("R1 reset addr %0d", a), 32'(d), 32'h0);
    end
    chk("R1 irq after reset", 32'(irq), 32'h0);

    // R2 R3 register map and write/readback
    for (int c = 0; c < NCH; c++) begin
      wr32(c, 0, 32'hA5A50000 + 32'(c));
      wr32(c, 2, 32'h12340000 + 32'(c));
    end
    for (int c = 0; c < NCH; c++) begin
      rd(ad(c, 0), d); chk("R2 R3 const hi", 32'(d), 32'hA5A5);
      rd(ad(c, 1), d); chk("R2 R3 const lo", 32'(d), 32'(c));
      rd_cnt(c, v);    chk("R2 R3 counter", v, 32'h12340000 + 32'(c));
    end
    wr(5'd0, 16'h5);
    rd(5'd0, d); chk("R2 start readback", 32'(d), 32'h5);
    wr(5'd0, 16'h0);

    // R4 stopped channel ignores ticks
    wr(ad(1, 4), ctl(4, 0, 0));
    wr32(1, 2, 32'd10);
    pulse(); pulse();
    rd_cnt(1, v); chk("R4 stopped holds", v, 32'd10);
    wr(5'd0, 16'h2);
    pulse(); pulse(); pulse();
    rd_cnt(1, v); chk("R4 three pulses", v, 32'd7);

    // R5 R6 R7 underflow, flag and irq
    wr32(1, 0, 32'd3);
    wr32(1, 2, 32'd0);
    wr(ad(1, 4), ctl(4, 1, 0));
    pulse();
    rd_cnt(1, v); chk("R5 reload not wrap", v, 32'd3);
    rd(ad(1, 4), d); chk("R6 flag set", 32'(d), 32'(ctl(4, 1, 1)));
    chk("R7 irq high", 32'(irq), 32'h2);
    wr(ad(1, 4), ctl(4, 1, 1));
    rd(ad(1, 4), d); chk("R6 write 1 keeps flag", 32'(d[8]), 32'h1);
    wr(ad(1, 4), ctl(4, 0, 1));
    @(negedge clk);
    chk("R7 irq masked by enable", 32'(irq), 32'h0);
    wr(ad(1, 4), ctl(4, 1, 0));
    @(negedge clk);
    rd(ad(1, 4), d); chk("R6 write 0 clears", 32'(d[8]), 32'h0);
    chk("R7 irq low after clear", 32'(irq), 32'h0);
    chk("R10 other channels idle", 32'(irq[0] | irq[2]), 32'h0);

    // R9 coherent read across a borrow
    wr32(1, 2, 32'h00010000);
    rd(ad(1, 3), d); chk("R9 low first", 32'(d), 32'h0000);
    pulse();
    rd(ad(1, 2), d); chk("R9 high from snapshot", 32'(d), 32'h0001);
    rd(ad(1, 3), d); chk("R9 fresh low", 32'(d), 32'hFFFF);
    rd(ad(1, 3), d); chk("R9 same half recaptures", 32'(d), 32'hFFFF);
    rd(ad(1, 2), d); chk("R9 high after recapture", 32'(d), 32'h0000);
    wr(5'd0, 16'h0);

    // R8 tap rates
    rate(0, 400, 99, 101, "R8 div4");
    rate(1, 800, 49, 51, "R8 div16");
    rate(2, 640, 9, 11, "R8 div64");
    rate(3, 2048, 7, 9, "R8 div256");
    rate(5, 600, 0, 0, "R8 code5 idle");
    rate(7, 600, 0, 0, "R8 code7 idle");

    // R3 R4 R5 R10 random phase against a model
    for (int c = 0; c < NCH; c++) wr(ad(c, 4), ctl(4, 0, 0));
    wr(5'd0, 16'h7);
    for (int it = 0; it < 40; it++) begin
      for (int c = 0; c < NCH; c++) begin
        m_cst[c] = $urandom_range(0, 5);
        m_cnt[c] = ($urandom_range(0, 3) == 0) ? 32'h00010002 : 32'($urandom_range(0, 8));
        m_ien[c] = 1'($urandom_range(0, 1));
        m_flg[c] = 0;
        wr32(c, 0, m_cst[c]);
        wr32(c, 2, m_cnt[c]);
        wr(ad(c, 4), ctl(4, m_ien[c], 0));
      end
      for (int t = 0; t < int'($urandom_range(1, 10)); t++) begin
        pulse();
        for (int c = 0; c < NCH; c++)
          if (m_cnt[c] == 0) begin m_cnt[c] = m_cst[c]; m_flg[c] = 1; end
          else m_cnt[c] = m_cnt[c] - 1;
      end
      for (int c = 0; c < NCH; c++) begin
        rd_cnt(c, v);
        chk($sformatf("R4 R5 R10 model ch%0d", c), v, m_cnt[c]);
        rd(ad(c, 4), d);
        chk($sformatf("R6 flag model ch%0d", c), 32'(d[8]), 32'(m_flg[c]));
        chk($sformatf("R7 irq model ch%0d", c), 32'(irq[c]), 32'(m_flg[c] & m_ien[c]));
      end
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule